// File: doc/BRIEF.md
# Read-Only I2C Byte Server

This block is an I2C target that only ever sends data. A capture stage elsewhere on the chip decodes a data line and presents five bytes on a parallel port with a one-cycle strobe. The block keeps those bytes and hands them to any bus master that addresses it for a read. It sends them in order, most significant bit first. After the last stored byte it sends all-ones filler for as long as the master keeps clocking.

The bus pins are open-drain. SCL is only observed, because the block never stretches the clock. SDA is observed, and the block pulls it low through a single enable output. A static select input chooses between two read addresses. Writes are never acknowledged.

A new snapshot can arrive while a master is reading. In that case it is held in a shadow copy and takes effect only once the bus STOP is seen. Every byte of one transaction therefore comes from the same snapshot.

Top module: `rdonly_i2c_tx`

## Requirements
- R1: After reset the block releases SDA (`sda_pull`=0), and every stored byte reads as 0x00 until the first load.
- R2: The block answers the full first byte 0x21 when `addr_sel`=1, or 0x23 when `addr_sel`=0. Bit 0 of that byte is the read flag. The block answers by pulling SDA low during the ninth SCL pulse.
- R3: For any other first byte, including any byte with bit 0 clear, the block gives no acknowledge. It then keeps SDA released until the next START.
- R4: The data bytes go out in index order 0 to 4, each MSB first. Byte k is `ld_data[8k+7:8k]` from the most recent applied load.
- R5: Every byte requested after the fifth is 0xFF, with no limit on the count.
- R6: The block releases SDA during every acknowledge slot after a data byte. After the master answers a byte with NACK, SDA stays released until the next START.
- R7: The SDA pull changes only while SCL is low. START is an SDA fall while SCL is high, and STOP is an SDA rise while SCL is high.
- R8: A repeated START restarts address decoding and sets the byte index back to 0.
- R9: A load strobed while no transaction is open (STOP to START) applies at once. A load strobed between a START and its STOP is held and applied after the STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| addr_sel | input | 1 | Selects read address 0x21 (1) or 0x23 (0) |
| ld_stb | input | 1 | One-cycle strobe that loads a new snapshot |
| ld_data | input | 40 | Snapshot bytes, byte k at bits 8k+7:8k |

## Verification
The bench sets the select pin both ways and checks that the other address, and a write to the block's own address, get no acknowledge. It then clocks a full byte after the refusal. A decoder that leaked into the data phase would pull SDA there.

Reads that run past the fifth byte must return filler. A pointer that wraps would repeat byte 0, and one that overruns would send stale values. Clocking a further byte after a NACK shows whether the block wrongly keeps sending.

A snapshot is loaded in the middle of a read. That read must keep the old bytes, and the next read must see the new ones. A design without the hold-off would send a mix of the two snapshots.

A repeated START after two bytes must bring back byte 0. A design that kept its index would send byte 2 instead.

// File: rtl/i2cro_pkg.sv
package i2cro_pkg;

    localparam int unsigned DEF_NUM_BYTES = 5;
    localparam int unsigned DEF_BW        = 8;
    localparam logic [5:0]  ADDR_UPPER    = 6'b001000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_TX,
        ST_MACK
    } eng_state_t;

    // Full first byte that the block answers: the select pin inverted sits
    // in bit 1, and the read flag is bit 0.
    function automatic logic [7:0] read_addr_byte(input logic sel);
        return {ADDR_UPPER, ~sel, 1'b1};
    endfunction

endpackage

// File: rtl/i2cro_sync.sv
module i2cro_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2cro_buf.sv
module i2cro_buf #(
    parameter int unsigned NUM_BYTES = 5,
    parameter int unsigned BW        = 8,
    localparam int unsigned PTR_W    = $clog2(NUM_BYTES + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ld_stb,
    input  logic [NUM_BYTES*BW-1:0]  ld_data,
    input  logic                     busy,
    input  logic [PTR_W-1:0]         rd_idx,
    output logic [BW-1:0]            rd_byte,
    output logic [NUM_BYTES*BW-1:0]  live_flat
);

    logic [BW-1:0] live_q [NUM_BYTES];
    logic [BW-1:0] shad_q [NUM_BYTES];
    logic          pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else if (ld_stb && busy) begin
            pend_q <= 1'b1;
        end else if (!busy) begin
            pend_q <= 1'b0;
        end
    end

    for (genvar k = 0; k < NUM_BYTES; k++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                live_q[k] <= '0;
                shad_q[k] <= '0;
            end else if (ld_stb && busy) begin
                shad_q[k] <= ld_data[k*BW +: BW];
            end else if (ld_stb) begin
                live_q[k] <= ld_data[k*BW +: BW];
            end else if (!busy && pend_q) begin
                live_q[k] <= shad_q[k];
            end
        end
        assign live_flat[k*BW +: BW] = live_q[k];
    end

    assign rd_byte = (rd_idx < PTR_W'(NUM_BYTES)) ? live_q[rd_idx] : '1;

endmodule

// File: rtl/i2cro_eng.sv
module i2cro_eng
    import i2cro_pkg::*;
#(
    parameter int unsigned NUM_BYTES = 5,
    parameter int unsigned BW        = 8,
    localparam int unsigned PTR_W    = $clog2(NUM_BYTES + 1),
    localparam int unsigned CNT_W    = $clog2(BW)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic [7:0]       my_addr,
    input  logic [BW-1:0]    byte_in,
    output logic [PTR_W-1:0] ptr,
    output logic             active,
    output logic             sda_pull,
    output eng_state_t       state
);

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BW - 1);
    localparam logic [PTR_W-1:0] PTR_END  = PTR_W'(NUM_BYTES);

    logic [CNT_W-1:0] cnt;
    logic [BW-2:0]    shreg;
    logic             ack_on;
    logic             nack_q;
    logic [PTR_W-1:0] ptr_nxt;

    assign ptr_nxt = (ptr == PTR_END) ? ptr : ptr + PTR_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            shreg    <= '0;
            ptr      <= '0;
            active   <= 1'b0;
            sda_pull <= 1'b0;
            ack_on   <= 1'b0;
            nack_q   <= 1'b0;
        end else if (start_det) begin
            state    <= ST_ADDR;
            active   <= 1'b1;
            cnt      <= '0;
            ptr      <= '0;
            sda_pull <= 1'b0;
            ack_on   <= 1'b0;
        end else if (stop_det) begin
            state    <= ST_IDLE;
            active   <= 1'b0;
            sda_pull <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_ADDR: if (scl_rise) begin
                    shreg <= {shreg[BW-3:0], sda_s};
                    if (cnt == CNT_LAST) begin
                        cnt    <= '0;
                        ack_on <= 1'b0;
                        state  <= ({shreg, sda_s} == my_addr) ? ST_AACK : ST_IDLE;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_AACK: if (scl_fall) begin
                    if (!ack_on) begin
                        ack_on   <= 1'b1;
                        sda_pull <= 1'b1;
                    end else begin
                        shreg    <= byte_in[BW-2:0];
                        sda_pull <= ~byte_in[BW-1];
                        cnt      <= '0;
                        ptr      <= ptr_nxt;
                        state    <= ST_TX;
                    end
                end
                ST_TX: if (scl_fall) begin
                    if (cnt == CNT_LAST) begin
                        sda_pull <= 1'b0;
                        state    <= ST_MACK;
                    end else begin
                        cnt      <= cnt + CNT_W'(1);
                        sda_pull <= ~shreg[BW-2];
                        shreg    <= {shreg[BW-3:0], 1'b0};
                    end
                end
                ST_MACK: begin
                    if (scl_rise) nack_q <= sda_s;
                    if (scl_fall) begin
                        if (nack_q) begin
                            state <= ST_IDLE;
                        end else begin
                            shreg    <= byte_in[BW-2:0];
                            sda_pull <= ~byte_in[BW-1];
                            cnt      <= '0;
                            ptr      <= ptr_nxt;
                            state    <= ST_TX;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rdonly_i2c_tx.sv
module rdonly_i2c_tx
    import i2cro_pkg::*;
#(
    parameter int unsigned NUM_BYTES   = DEF_NUM_BYTES,
    parameter int unsigned BW          = DEF_BW,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned PTR_W      = $clog2(NUM_BYTES + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    scl_i,
    input  logic                    sda_i,
    output logic                    sda_pull,
    input  logic                    addr_sel,
    input  logic                    ld_stb,
    input  logic [NUM_BYTES*BW-1:0] ld_data
);

    logic                    scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [PTR_W-1:0]        eng_ptr;
    logic                    eng_active;
    eng_state_t              eng_state;
    logic [BW-1:0]           cur_byte;
    logic [NUM_BYTES*BW-1:0] live_flat;

    i2cro_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2cro_buf #(.NUM_BYTES(NUM_BYTES), .BW(BW)) buf_i (
        .clk(clk), .rst(rst), .ld_stb(ld_stb), .ld_data(ld_data),
        .busy(eng_active), .rd_idx(eng_ptr), .rd_byte(cur_byte),
        .live_flat(live_flat)
    );

    i2cro_eng #(.NUM_BYTES(NUM_BYTES), .BW(BW)) eng_i (
        .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .my_addr(read_addr_byte(addr_sel)), .byte_in(cur_byte),
        .ptr(eng_ptr), .active(eng_active), .sda_pull(sda_pull),
        .state(eng_state)
    );

endmodule

// File: rtl/rdonly_i2c_tx_chk.sv
module rdonly_i2c_tx_chk
    import i2cro_pkg::*;
#(
    parameter int unsigned NUM_BYTES = 5,
    parameter int unsigned BW        = 8,
    localparam int unsigned PTR_W    = $clog2(NUM_BYTES + 1)
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    scl_s,
    input logic                    sda_pull,
    input eng_state_t              state,
    input logic [PTR_W-1:0]        ptr,
    input logic                    active,
    input logic [NUM_BYTES*BW-1:0] live_flat
);

    a_r7_pull_rises_scl_low: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull) |-> !scl_s);

    a_r3_idle_released: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_pull);

    a_r6_mack_released: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MACK) |-> !sda_pull);

    a_r5_ptr_bound: assert property (@(posedge clk) disable iff (rst)
        ptr <= PTR_W'(NUM_BYTES));

    a_r9_hold_stable: assert property (@(posedge clk) disable iff (rst)
        !$stable(live_flat) |-> !$past(active));

endmodule

bind rdonly_i2c_tx rdonly_i2c_tx_chk #(.NUM_BYTES(NUM_BYTES), .BW(BW)) chk_i (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_pull(sda_pull),
    .state(eng_state), .ptr(eng_ptr), .active(eng_active),
    .live_flat(live_flat)
);

// File: tb/rdonly_i2c_tx_tb_top.sv
module rdonly_i2c_tx_tb_top;

    localparam int Q = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        addr_sel = 1'b1;
    logic        ld_stb = 1'b0;
    logic [39:0] ld_data = '0;
    logic        sda_pull;
    logic        sda_bus;
    int          n_run = 0;
    int          n_fail = 0;
    int          oe_cnt = 0;
    int          r7_viol = 0;
    logic        pull_prev = 1'b0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    assign sda_bus = sda_m & ~sda_pull;

    rdonly_i2c_tx dut_i (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_pull(sda_pull), .addr_sel(addr_sel), .ld_stb(ld_stb),
        .ld_data(ld_data)
    );

    always @(posedge clk) begin
        oe_cnt    <= oe_cnt + int'(sda_pull);
        pull_prev <= sda_pull;
        if (!rst && sda_pull != pull_prev && scl_m) r7_viol <= r7_viol + 1;
    end

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start;
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic i2c_stop;
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(Q);
    endtask

    task automatic wr_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(Q);
            scl_m = 1'b1; wq(2*Q);
            scl_m = 1'b0;
        end
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        acked = !sda_bus; wq(Q);
        scl_m = 1'b0;
    endtask

    task automatic rd_byte(output logic [7:0] b, input bit give_ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; wq(Q);
            scl_m = 1'b1; wq(Q);
            b[i] = sda_bus; wq(Q);
            scl_m = 1'b0;
        end
        sda_m = give_ack ? 1'b0 : 1'b1; wq(Q);
        scl_m = 1'b1; wq(2*Q);
        scl_m = 1'b0; wq(2);
        sda_m = 1'b1;
    endtask

    task automatic load(input logic [39:0] d);
        @(negedge clk);
        ld_data = d; ld_stb = 1'b1;
        @(negedge clk);
        ld_stb = 1'b0;
    endtask

    task automatic t_reset;
        bit ack; logic [7:0] b;
        check("R1 pull released after reset", int'(sda_pull), 0);
        i2c_start; wr_byte(8'h21, ack);
        check("R2 ack 0x21 sel=1", int'(ack), 1);
        rd_byte(b, 1'b0);
        check("R1 byte0 before load", int'(b), 8'h00);
        i2c_stop;
    endtask

    task automatic t_read5;
        bit ack; logic [7:0] b;
        logic [7:0] exp [5] = '{8'hA5, 8'h80, 8'h01, 8'h3C, 8'hC3};
        load({exp[4], exp[3], exp[2], exp[1], exp[0]});
        i2c_start; wr_byte(8'h21, ack);
        check("R2 ack read5", int'(ack), 1);
        for (int k = 0; k < 5; k++) begin
            rd_byte(b, k < 4);
            check($sformatf("R4 byte %0d", k), int'(b), int'(exp[k]));
        end
        i2c_stop;
    endtask

    task automatic t_fill;
        bit ack; logic [7:0] b;
        i2c_start; wr_byte(8'h21, ack);
        for (int k = 0; k < 8; k++) begin
            rd_byte(b, k < 7);
            if (k >= 5) check($sformatf("R5 filler byte %0d", k), int'(b), 8'hFF);
        end
        i2c_stop;
    endtask

    task automatic t_nack_end;
        bit ack; logic [7:0] b; int c0;
        i2c_start; wr_byte(8'h21, ack);
        rd_byte(b, 1'b0);
        check("R6 first byte before nack", int'(b), 8'hA5);
        c0 = oe_cnt;
        rd_byte(b, 1'b0);
        check("R6 released after nack", oe_cnt - c0, 0);
        check("R6 line high after nack", int'(b), 8'hFF);
        i2c_stop;
    endtask

    task automatic t_sel_low;
        bit ack; logic [7:0] b; int c0;
        addr_sel = 1'b0; wq(2);
        i2c_start; wr_byte(8'h23, ack);
        check("R2 ack 0x23 sel=0", int'(ack), 1);
        rd_byte(b, 1'b0);
        check("R4 byte0 sel=0", int'(b), 8'hA5);
        i2c_stop;
        i2c_start; c0 = oe_cnt; wr_byte(8'h21, ack);
        check("R3 no ack 0x21 sel=0", int'(ack), 0);
        rd_byte(b, 1'b0);
        check("R3 released after mismatch", oe_cnt - c0, 0);
        i2c_stop;
        addr_sel = 1'b1; wq(2);
    endtask

    task automatic t_write;
        bit ack; logic [7:0] b; int c0;
        i2c_start; c0 = oe_cnt; wr_byte(8'h20, ack);
        check("R3 no ack write", int'(ack), 0);
        rd_byte(b, 1'b0);
        check("R3 released after write", oe_cnt - c0, 0);
        i2c_stop;
    endtask

    task automatic t_holdoff;
        bit ack; logic [7:0] b;
        i2c_start; wr_byte(8'h21, ack);
        rd_byte(b, 1'b1);
        load({8'h55, 8'h44, 8'h33, 8'h22, 8'h11});
        rd_byte(b, 1'b1);
        check("R9 old byte1 during hold", int'(b), 8'h80);
        rd_byte(b, 1'b0);
        check("R9 old byte2 during hold", int'(b), 8'h01);
        i2c_stop;
        i2c_start; wr_byte(8'h21, ack);
        rd_byte(b, 1'b1);
        check("R9 new byte0 after stop", int'(b), 8'h11);
        rd_byte(b, 1'b0);
        check("R9 new byte1 after stop", int'(b), 8'h22);
        i2c_stop;
    endtask

    task automatic t_rstart;
        bit ack; logic [7:0] b;
        i2c_start; wr_byte(8'h21, ack);
        rd_byte(b, 1'b1);
        rd_byte(b, 1'b0);
        check("R8 byte1 before restart", int'(b), 8'h22);
        i2c_start; wr_byte(8'h21, ack);
        check("R8 ack after restart", int'(ack), 1);
        rd_byte(b, 1'b0);
        check("R8 byte0 after restart", int'(b), 8'h11);
        i2c_stop;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        wq(5);
        rst = 1'b0;
        wq(5);
        t_reset;
        t_read5;
        t_fill;
        t_nack_end;
        t_sel_low;
        t_write;
        t_holdoff;
        t_rstart;
        check("R7 pull changed with SCL high", r7_viol, 0);
        finish_run;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run;
    end

endmodule